// File: doc/BRIEF.md
# USB Link Status LED Controller

This block drives one status LED that shows the health of a USB device connection. It takes event strobes and state flags from the device core and turns them into a single registered, active-high LED level. A person watching the LED can tell whether the device is idle, enumerating, configured and carrying traffic, or suspended.

The LED follows four rules. Before configuration it rests dark and flashes on briefly for each enumeration transaction. Once the device is configured it stays lit and flashes off briefly for each transfer that completed with an acknowledgement. Suspend forces it dark, whatever else is happening. A pulse-stretch counter, loaded from the `BLINK_CYCLES` parameter, turns a one-clock strobe into a flash long enough to see. A strobe that arrives while a flash is already running restarts the flash. Strobes are not queued.

Top module: `usb_status_led`

## Requirements
- R1: After reset is released, `led_o` is 0 and no flash is running.
- R2: With `configured_i` = 0, `suspend_i` = 0 and no flash running, `led_o` is 0.
- R3: With `configured_i` = 0, an `enum_evt_i` strobe sampled at a clock edge sets `led_o` to 1 at that edge. The LED stays at 1 for exactly `BLINK_CYCLES` clocks and then returns to 0.
- R4: With `configured_i` = 1, `suspend_i` = 0 and no flash running, `led_o` is 1.
- R5: With `configured_i` = 1, an `ack_xfer_i` strobe sampled at a clock edge sets `led_o` to 0 at that edge. The LED stays at 0 for exactly `BLINK_CYCLES` clocks and then returns to 1.
- R6: When `suspend_i` is 1 at a clock edge, `led_o` is 0 after that edge. Strobes sampled during suspend start no flash. After suspend ends, the LED shows the steady level for the current `configured_i` value.
- R7: A strobe of the current mode that arrives during a flash restarts the flash. The LED then holds the flash level for `BLINK_CYCLES` clocks counted from the new strobe.
- R8: A strobe that does not belong to the current mode has no effect: `ack_xfer_i` while unconfigured, and `enum_evt_i` while configured.
- R9: A change of `configured_i` cancels any running flash. The LED takes the steady level of the new mode at the edge where the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enum_evt_i | input | 1 | One-clock strobe per enumeration transaction |
| ack_xfer_i | input | 1 | One-clock strobe per acknowledged transfer |
| configured_i | input | 1 | Device is enumerated and configured |
| suspend_i | input | 1 | Bus is suspended |
| led_o | output | 1 | Registered active-high LED drive |

## Verification
The hardest situations to reach are the collisions. These are a strobe landing on the same edge as a change of `configured_i` or the start of suspend, and a retrigger on the last cycle of a flash. Directed sequences cannot cover every such combination. The bench therefore runs a small flash length of four clocks and drives thousands of cycles of pseudo-random input combinations. The strobes are dense and suspend is frequent, so every ordering of strobe, mode change and suspend against every counter value occurs many times. Each cycle is compared with an arithmetic reference computed in the bench.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

  typedef enum logic {
    MODE_ENUM = 1'b0,
    MODE_CONF = 1'b1
  } link_mode_e;

  // Strobe that counts as a flash trigger in the given mode.
  function automatic logic pick_trigger(link_mode_e mode, logic enum_evt, logic ack_xfer);
    return (mode == MODE_CONF) ? ack_xfer : enum_evt;
  endfunction

  // Next value of the pulse-stretch count; clear beats load beats decrement.
  function automatic int unsigned stretch_next(int unsigned cur, logic load, logic clr,
                                               int unsigned full);
    if (clr)         return 0;
    else if (load)   return full;
    else if (cur != 0) return cur - 1;
    else             return 0;
  endfunction

  // LED level: dark in suspend, else steady level inverted while flashing.
  function automatic logic led_level(logic susp, link_mode_e mode, logic flashing);
    if (susp) return 1'b0;
    return (mode == MODE_CONF) ^ flashing;
  endfunction

endpackage

// File: rtl/led_mode_track.sv
module led_mode_track
  import led_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       configured_i,
  input  logic       suspend_i,
  input  logic       enum_evt_i,
  input  logic       ack_xfer_i,
  output link_mode_e mode_o,
  output logic       mode_chg_o,
  output logic       trig_o
);

  link_mode_e prev_q;

  assign mode_o     = configured_i ? MODE_CONF : MODE_ENUM;
  assign mode_chg_o = (mode_o != prev_q);
  assign trig_o     = !suspend_i && pick_trigger(mode_o, enum_evt_i, ack_xfer_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= MODE_ENUM;
    else        prev_q <= mode_o;
  end

  // R8: an off-mode strobe alone never triggers
  p_wrong_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_i && !ack_xfer_i) || (!configured_i && !enum_evt_i) |-> !trig_o);

  // R6: suspend blocks every trigger
  p_no_trig_susp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |-> !trig_o);

endmodule

// File: rtl/led_stretch.sv
module led_stretch
  import led_status_pkg::*;
#(
  parameter int unsigned BLINK_CYCLES = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clr_i,
  output logic flash_next_o,
  output logic idle_o
);

  localparam int unsigned CW = $clog2(BLINK_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(BLINK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d        = CW'(stretch_next(32'(cnt_q), load_i, clr_i, BLINK_CYCLES));
  assign flash_next_o = (cnt_d != '0);
  assign idle_o       = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: a trigger always restarts from the full length
  p_reload_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (cnt_q == FULL));

  // R3: a running flash counts down by one per clock
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9: clear empties the counter
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R3: count never exceeds the configured length
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/usb_status_led.sv
module usb_status_led
  import led_status_pkg::*;
#(
  parameter int unsigned BLINK_CYCLES = 6_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enum_evt_i,
  input  logic ack_xfer_i,
  input  logic configured_i,
  input  logic suspend_i,
  output logic led_o
);

  link_mode_e mode;
  logic       mode_chg;
  logic       trig;
  logic       clr;
  logic       flash_next;
  logic       idle;
  logic       led_q;

  led_mode_track u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .configured_i (configured_i),
    .suspend_i    (suspend_i),
    .enum_evt_i   (enum_evt_i),
    .ack_xfer_i   (ack_xfer_i),
    .mode_o       (mode),
    .mode_chg_o   (mode_chg),
    .trig_o       (trig)
  );

  assign clr = suspend_i || mode_chg;

  led_stretch #(.BLINK_CYCLES(BLINK_CYCLES)) u_stretch (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (trig),
    .clr_i        (clr),
    .flash_next_o (flash_next),
    .idle_o       (idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_level(suspend_i, mode, flash_next);
  end

  assign led_o = led_q;

  // R6: suspend darkens the LED at the next edge
  p_suspend_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |=> !led_o);

  // R9: a mode change lands on the steady level of the new mode
  p_mode_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !suspend_i) |=> (led_o == $past(configured_i)));

  // R4: configured, no flash pending or starting -> lit
  p_conf_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (configured_i && !suspend_i && !mode_chg && !ack_xfer_i && idle) |=> led_o);

  // R2: unconfigured, no flash pending or starting -> dark
  p_enum_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!configured_i && !enum_evt_i && idle) |=> !led_o);

endmodule

// File: tb/tb_usb_status_led.sv
module tb_usb_status_led;

  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enum_evt_i = 1'b0, ack_xfer_i = 1'b0, configured_i = 1'b0, suspend_i = 1'b0;
  logic led_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  int  rem = 0;
  logic prev_cfg = 1'b0;

  always #4 clk = ~clk;

  usb_status_led #(.BLINK_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .enum_evt_i(enum_evt_i), .ack_xfer_i(ack_xfer_i),
    .configured_i(configured_i), .suspend_i(suspend_i), .led_o(led_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: led_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle, advance the reference, compare after the edge.
  task automatic step(logic en, logic ack, logic cfg, logic sus, string req);
    logic exp;
    bit   hit;
    @(negedge clk);
    enum_evt_i = en; ack_xfer_i = ack; configured_i = cfg; suspend_i = sus;
    @(posedge clk);
    #1;
    hit = cfg ? ack : en;
    if (sus || (cfg != prev_cfg)) rem = 0;
    else if (hit)                 rem = N;
    else if (rem > 0)             rem = rem - 1;
    prev_cfg = cfg;
    exp = sus ? 1'b0 : (cfg ^ (rem > 0));
    check(req, led_o, exp);
  endtask

  // Count consecutive cycles at a level while idling in a mode.
  task automatic run_len(logic cfg, logic lvl, int exp_len, string req);
    int n = 0;
    for (int i = 0; i < 3 * N; i++) begin
      step(1'b0, 1'b0, cfg, 1'b0, req);
      if (led_o == lvl && n == i) n++;
    end
    checks++;
    if (n != exp_len) begin
      errors++;
      $display("FAIL %s: flash length %0d expected %0d", req, n, exp_len);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", led_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", led_o, 1'b0);

    // R2 idle unconfigured
    step(0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, "R2");
    // R3 enumeration flash: strobe edge plus N-1 more idle cycles at 1
    step(1, 0, 0, 0, "R3");
    run_len(1'b0, 1'b1, N - 1, "R3");
    // R8 ack while unconfigured ignored
    step(0, 1, 0, 0, "R8");
    check("R8", led_o, 1'b0);
    // R9 configured rises -> lit at that edge
    step(0, 0, 1, 0, "R9");
    check("R9", led_o, 1'b1);
    // R4 steady lit
    step(0, 0, 1, 0, "R4");
    // R5 ack flash off
    step(0, 1, 1, 0, "R5");
    check("R5", led_o, 1'b0);
    run_len(1'b1, 1'b0, N - 1, "R5");
    // R8 enum while configured ignored
    step(1, 0, 1, 0, "R8");
    check("R8", led_o, 1'b1);
    // R7 retrigger mid flash
    step(0, 1, 1, 0, "R7");
    step(0, 0, 1, 0, "R7");
    step(0, 1, 1, 0, "R7");
    run_len(1'b1, 1'b0, N - 1, "R7");
    // R6 suspend dark, strobes ignored, restore steady level
    step(0, 1, 1, 1, "R6");
    check("R6", led_o, 1'b0);
    step(1, 1, 1, 1, "R6");
    step(0, 0, 1, 0, "R6");
    check("R6", led_o, 1'b1);
    // R9 drop of configured cancels a flash
    step(0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, "R9");
    check("R9", led_o, 1'b0);

    // near-exhaustive pseudo-random sweep against the reference
    for (int i = 0; i < 6000; i++) begin
      logic sus;
      logic cfg;
      string tag;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sus = (lfsr[3:0] == 4'h0);
      cfg = (lfsr[9:6] == 4'h0) ? ~prev_cfg : prev_cfg;
      if (sus)                  tag = "R6";
      else if (cfg != prev_cfg) tag = "R9";
      else if (rem > 0)         tag = "R7";
      else if (cfg)             tag = "R5";
      else                      tag = "R3";
      step(lfsr[4], lfsr[5], cfg, sus, tag);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule